// File: doc/BRIEF.md
# Single-Shot Pulse Timer

This block generates exactly one output pulse whose length is set by a programmable reload value, then halts until it is armed again. Software first writes the reload value, then starts the timer either by writing 1 to an enable command or by a rising edge on an external trigger pin. All counting is paced by a count-clock tick. That tick is a single-cycle enable in the system clock domain, so the timer can run at any integer fraction of the system clock.

When counting starts, the counter is loaded from the reload register and the output flip-flop inverts. The counter then decrements once per tick. On the tick after it has reached zero, the counter underflows. At that point the flip-flop inverts back, an interrupt request and a DMA request are each strobed for one system clock, and the timer stops. With a reload value of N, the output stays at its active level for N+1 ticks.

Software enable, software disable, the external trigger and the underflow stop can all land in the same count period. Fixed priority rules decide the outcome. A disable write beats everything. An enable write beats the underflow stop. The underflow stop beats the trigger.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, `pulse_out` equals parameter `OUT_IDLE`, `running` is 0, `count` is 0, and `irq_req` and `dma_req` are 0.
- R2: A start takes effect on the first tick edge at or after the enable write or the synchronized trigger edge. On that edge `count` becomes the reload value and `pulse_out` inverts.
- R3: While running, `count` decreases by one per tick. On the tick where `count` is already 0, the timer underflows and stops, and `count` stays 0. The active level lasts reload+1 ticks, and the counter never restarts by itself.
- R4: `pulse_out` inverts at start and again at underflow. `OUT_IDLE`=0 yields a high pulse, and `OUT_IDLE`=1 yields a low pulse.
- R5: On the system clock after the underflow tick edge, `irq_req` and `dma_req` are both 1 for exactly one system clock.
- R6: A rising edge on `ext_trig` passes a two-flop synchronizer and then starts an idle timer. An edge that arrives while the timer is counting is ignored.
- R7: If an underflow and a trigger edge fall in the same count period, the timer stops and stays stopped.
- R8: If an underflow and an enable write of 1 fall in the same count period, counting restarts. `count` reloads, `pulse_out` keeps its active level, and the underflow request still fires.
- R9: If a trigger edge and an enable write of 0 fall in the same count period, the timer stays stopped.
- R10: On clock edges with `cnt_tick` low, `count`, `pulse_out` and `running` do not change. An enable write is held until the next tick edge. When several writes arrive before that tick, the last one wins.
- R11: A reload write during a pulse does not change that pulse's length. An enable write of 0 during a pulse stops the timer, and `count` and `pulse_out` keep their current values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count-clock enable, one system clock wide |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | W | Reload value |
| en_we | input | 1 | Enable command write strobe |
| en_wdata | input | 1 | Enable command value (1 start, 0 stop) |
| ext_trig | input | 1 | Asynchronous external start trigger |
| pulse_out | output | 1 | Output flip-flop level |
| irq_req | output | 1 | Interrupt request strobe at underflow |
| dma_req | output | 1 | DMA request strobe at underflow |
| running | output | 1 | Timer counting |
| count | output | W | Current counter value |

## Verification
A corrupted counter shows up as a wrong pulse length, and it is visible on the first tick edge after the start, because `count` must then equal the reload value. A wrong arbitration outcome shows up on `running` and `pulse_out` within one system clock of the contested tick edge. The sweeps measure active ticks and request strobes over every small reload value, at two tick rates and through both start paths. This means a counter that is off by one, a stuck flip-flop or a lost request shows up when the pulse ends.

// File: rtl/osp_pkg.sv
package osp_pkg;

  typedef struct packed {
    logic set;
    logic clr;
    logic trig;
  } osp_cmd_t;

  // Priority: disable > software enable > underflow stop > trigger start
  function automatic logic arb_next_run(input logic run, input osp_cmd_t c,
                                        input logic uf);
    logic r;
    if (c.clr)      r = 1'b0;
    else if (c.set) r = 1'b1;
    else if (uf)    r = 1'b0;
    else if (c.trig) r = 1'b1;
    else            r = run;
    return r;
  endfunction

  // Number of ticks the output spends at its active level
  function automatic int unsigned active_ticks(input int unsigned reload);
    return reload + 1;
  endfunction

endpackage

// File: rtl/osp_swcmd.sv
module osp_swcmd (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en_we,
  input  logic en_wdata,
  output logic set_eff,
  output logic clr_eff
);
  logic set_p, clr_p;
  logic wr_set, wr_clr;

  assign wr_set = en_we & en_wdata;
  assign wr_clr = en_we & ~en_wdata;

  // Latest write wins over an older pending one
  assign set_eff = wr_set | (set_p & ~wr_clr);
  assign clr_eff = wr_clr | (clr_p & ~wr_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_p <= 1'b0;
      clr_p <= 1'b0;
    end else if (tick) begin
      set_p <= 1'b0;
      clr_p <= 1'b0;
    end else if (en_we) begin
      set_p <= en_wdata;
      clr_p <= ~en_wdata;
    end
  end
endmodule

// File: rtl/osp_trig.sv
module osp_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trig_in,
  output logic trig_eff
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic                   rise;
  logic                   pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= sync_q[LAST];
  end

  assign rise     = sync_q[LAST] & ~hist_q;
  assign trig_eff = rise | pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (tick) pend_q <= 1'b0;
    else if (rise) pend_q <= 1'b1;
  end
endmodule

// File: rtl/osp_core.sv
module osp_core
  import osp_pkg::*;
#(
  parameter int   W        = 16,
  parameter logic OUT_IDLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  osp_cmd_t     cmd,
  input  logic [W-1:0] reload_q,
  output logic         running,
  output logic [W-1:0] count,
  output logic         pulse,
  output logic         req,
  output logic         ev_start,
  output logic         ev_uf
);
  logic run_d;

  always_comb begin
    ev_uf    = tick & running & (count == '0);
    run_d    = arb_next_run(running, cmd, ev_uf);
    ev_start = tick & run_d & (~running | ev_uf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
      pulse   <= OUT_IDLE;
    end else if (tick) begin
      running <= run_d;
      pulse   <= pulse ^ ev_start ^ ev_uf;
      if (ev_start)
        count <= reload_q;
      else if (running && run_d && !ev_uf)
        count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= ev_uf;
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import osp_pkg::*;
#(
  parameter int   W        = 16,
  parameter logic OUT_IDLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_tick,
  input  logic         reload_we,
  input  logic [W-1:0] reload_wdata,
  input  logic         en_we,
  input  logic         en_wdata,
  input  logic         ext_trig,
  output logic         pulse_out,
  output logic         irq_req,
  output logic         dma_req,
  output logic         running,
  output logic [W-1:0] count
);
  logic [W-1:0] reload_q;
  osp_cmd_t     cmd;
  logic         cmd_set, cmd_clr, cmd_trig;
  logic         ev_start, ev_uf;
  logic         req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_we) reload_q <= reload_wdata;
  end

  osp_swcmd u_swcmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cnt_tick),
    .en_we   (en_we),
    .en_wdata(en_wdata),
    .set_eff (cmd_set),
    .clr_eff (cmd_clr)
  );

  osp_trig #(.SYNC_STAGES(2)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cnt_tick),
    .trig_in (ext_trig),
    .trig_eff(cmd_trig)
  );

  assign cmd = '{set: cmd_set, clr: cmd_clr, trig: cmd_trig};

  osp_core #(.W(W), .OUT_IDLE(OUT_IDLE)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cnt_tick),
    .cmd     (cmd),
    .reload_q(reload_q),
    .running (running),
    .count   (count),
    .pulse   (pulse_out),
    .req     (req),
    .ev_start(ev_start),
    .ev_uf   (ev_uf)
  );

  assign irq_req = req;
  assign dma_req = req;
endmodule

// File: rtl/osp_checker.sv
module osp_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_tick,
  input logic         cmd_set,
  input logic         cmd_clr,
  input logic         cmd_trig,
  input logic         ev_start,
  input logic         ev_uf,
  input logic [W-1:0] reload_q,
  input logic         running,
  input logic [W-1:0] count,
  input logic         pulse_out,
  input logic         irq_req
);
  a_r2_load_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> count == $past(reload_q));

  a_r4_start_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !ev_uf) |=> pulse_out != $past(pulse_out));

  a_r3_uf_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_uf && !cmd_set) |=> (!running && pulse_out != $past(pulse_out)));

  a_r5_req_after_uf: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(ev_uf));

  a_r7_uf_beats_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_uf && cmd_trig && !cmd_set) |=> !running);

  a_r8_set_beats_uf: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_uf && cmd_set && !cmd_clr) |=> (running && pulse_out == $past(pulse_out)));

  a_r9_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && cmd_clr) |=> !running);

  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> ($stable(count) && $stable(pulse_out) && $stable(running)));
endmodule

bind oneshot_timer osp_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_tick (cnt_tick),
  .cmd_set  (cmd_set),
  .cmd_clr  (cmd_clr),
  .cmd_trig (cmd_trig),
  .ev_start (ev_start),
  .ev_uf    (ev_uf),
  .reload_q (reload_q),
  .running  (running),
  .count    (count),
  .pulse_out(pulse_out),
  .irq_req  (irq_req)
);

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_tick = 1'b0;
  logic         reload_we = 1'b0;
  logic [W-1:0] reload_wdata = '0;
  logic         en_we = 1'b0;
  logic         en_wdata = 1'b0;
  logic         ext_trig = 1'b0;
  logic         pulse_out, irq_req, dma_req, running;
  logic [W-1:0] count;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  int act_ticks = 0;
  int irq_seen = 0;
  logic last_t = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  oneshot_timer #(.W(W), .OUT_IDLE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
    .reload_we(reload_we), .reload_wdata(reload_wdata),
    .en_we(en_we), .en_wdata(en_wdata), .ext_trig(ext_trig),
    .pulse_out(pulse_out), .irq_req(irq_req), .dma_req(dma_req),
    .running(running), .count(count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One system clock; strobes are single-cycle
  task automatic edge_t(input logic t);
    cnt_tick = t;
    @(posedge clk);
    #2;
    last_t = t;
    cnt_tick = 1'b0;
    reload_we = 1'b0;
    en_we = 1'b0;
    if (irq_req) irq_seen++;
    if (irq_req != dma_req) chk(0, "R5 irq/dma mismatch", dma_req, irq_req);
    if (t && pulse_out) act_ticks++;
  endtask

  task automatic step(input int div);
    edge_t((ph % div) == div - 1);
    ph++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ext_trig = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    ph = 0;
  endtask

  task automatic write_reload(input int v);
    reload_we = 1'b1;
    reload_wdata = W'(v);
    edge_t(1'b0);
  endtask

  // Full pulse: start by software or trigger, optional reload rewrite mid-run
  task automatic measure(input int r, input int div, input bit use_trig,
                         input int mid_k, input string tag);
    bit started = 0;
    write_reload(r);
    act_ticks = 0;
    irq_seen = 0;
    ph = 0;
    if (use_trig) ext_trig = 1'b1;
    else begin en_we = 1'b1; en_wdata = 1'b1; end
    for (int k = 0; k < (r + 8) * div; k++) begin
      if (k == 3) ext_trig = 1'b0;
      if (k == mid_k) begin reload_we = 1'b1; reload_wdata = W'(1); end
      step(div);
      if (last_t && !started && running) begin
        started = 1;
        chk(count == W'(r), {tag, " R2 load"}, count, r);
        chk(pulse_out == 1'b1, {tag, " R4 start level"}, pulse_out, 1);
      end
    end
    chk(started, {tag, " R2 started"}, started, 1);
    chk(act_ticks == int'(r + 1), {tag, " R3 width"}, act_ticks, r + 1);
    chk(irq_seen == 1, {tag, " R5 req count"}, irq_seen, 1);
    chk(!running && !pulse_out && count == 0, {tag, " R3 stopped"},
        {running, pulse_out}, 0);
  endtask

  task automatic run_to_zero(input int div);
    for (int k = 0; k < 200 && !(last_t && running && count == 0); k++) step(div);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk(pulse_out == 1'b0, "R1 idle level", pulse_out, 0);
    chk(!running && count == 0, "R1 idle state", count, 0);
    chk(!irq_req && !dma_req, "R1 no requests", irq_req, 0);

    // R2 R3 R4 R5: sweeps at two tick rates
    for (int r = 0; r <= 12; r++) measure(r, 1, 0, -1, "sw div1");
    for (int r = 0; r <= 12; r++) measure(r, 3, 0, -1, "sw div3");

    // R6: trigger start
    for (int r = 0; r <= 6; r++) measure(r, 2, 1, -1, "R6 trig");

    // R11: reload rewrite during run keeps length
    measure(5, 1, 0, 3, "R11 reload mid-run");

    // R6: trigger while running ignored
    write_reload(6);
    act_ticks = 0; irq_seen = 0; ph = 0;
    en_we = 1'b1; en_wdata = 1'b1;
    for (int k = 0; k < 40; k++) begin
      ext_trig = (k >= 4 && k < 7);
      step(2);
    end
    chk(act_ticks == 7, "R6 trig ignored width", act_ticks, 7);
    chk(irq_seen == 1 && !running, "R6 trig ignored once", irq_seen, 1);

    // R7: trigger in the underflow period
    write_reload(2);
    irq_seen = 0; ph = 0;
    en_we = 1'b1; en_wdata = 1'b1;
    run_to_zero(4);
    ext_trig = 1'b1;
    for (int k = 0; k < 4; k++) begin step(4); if (k == 1) ext_trig = 1'b0; end
    chk(!running && !pulse_out, "R7 stop beats trigger", running, 0);
    chk(irq_seen == 1, "R7 request", irq_seen, 1);
    for (int k = 0; k < 16; k++) step(4);
    chk(!running && !pulse_out, "R7 stays stopped", running, 0);

    // R8: enable write in the underflow period
    write_reload(2);
    irq_seen = 0; act_ticks = 0; ph = 0;
    en_we = 1'b1; en_wdata = 1'b1;
    run_to_zero(4);
    en_we = 1'b1; en_wdata = 1'b1;
    step(4);
    while (!last_t) step(4);
    chk(running && count == 2, "R8 restart reload", count, 2);
    chk(pulse_out == 1'b1, "R8 level held", pulse_out, 1);
    chk(irq_req == 1'b1, "R8 request fires", irq_req, 0);
    for (int k = 0; k < 20; k++) step(4);
    chk(act_ticks == 6 && irq_seen == 2 && !running, "R8 second pulse",
        act_ticks, 6);

    // R9: trigger and disable in one period
    write_reload(3);
    ph = 0;
    ext_trig = 1'b1;
    step(8); step(8); step(8);
    ext_trig = 1'b0;
    en_we = 1'b1; en_wdata = 1'b0;
    for (int k = 0; k < 16; k++) step(8);
    chk(!running && !pulse_out, "R9 disable beats trigger", running, 0);

    // R10: held write waits for tick, last write wins
    write_reload(4);
    en_we = 1'b1; en_wdata = 1'b1;
    edge_t(1'b0);
    for (int k = 0; k < 5; k++) edge_t(1'b0);
    chk(!running && !pulse_out, "R10 no tick no start", running, 0);
    edge_t(1'b1);
    chk(running && count == 4 && pulse_out, "R10 start on tick", count, 4);
    edge_t(1'b1);
    for (int k = 0; k < 5; k++) edge_t(1'b0);
    chk(count == 3 && running, "R10 hold without tick", count, 3);
    en_we = 1'b1; en_wdata = 1'b1; edge_t(1'b0);
    en_we = 1'b1; en_wdata = 1'b0; edge_t(1'b0);
    edge_t(1'b1);
    // R11: disable mid-run holds count and level
    chk(!running && count == 3, "R11 stop holds count", count, 3);
    chk(pulse_out == 1'b1, "R11 stop holds level", pulse_out, 1);
    for (int k = 0; k < 6; k++) edge_t(1'b1);
    chk(!running && count == 3 && pulse_out, "R11 remains stopped", count, 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule